// File: doc/BRIEF.md
# Token-Chained Multi-Board Readout Decoder

This block sits between a 32-bit bus slave front end and the event data FIFO of one board in a crate of readout boards. It decodes two address windows that pull event data out of the FIFO. The private window belongs to this board alone. It is an 8 MB region whose base is programmable, and any read inside it pops the next data word, whatever the offset. A bus master can therefore let its address run upward during a block read. The one legal write into the private window is the rearm word 0x80000000, which re-enables interrupt generation.

The shared window spans an address range common to every board in the chain. Only the board that holds a daisy-chained token answers there. The holder counts the complete events it sends. Once it has delivered the programmed block size, a board in the middle of the chain hands the token on with a one-cycle pulse. The board at the end of the chain keeps the token and ends the block transfer with a bus error termination. This lets one logical block read collect data from several boards in turn.

Responses are registered: a request seen on one clock edge is answered on the following cycle. If both windows match one address, the private window has priority.

Top module: `chain_readout_dec`

## Requirements
- R1: With priv_en high, a read whose address bits [31:23] equal priv_base is a private hit at any offset. If the FIFO is not empty, fifo_pop is high in the request cycle, and in the next cycle bus_ack is high with bus_rdata equal to the popped word.
- R2: A private-window write of 0x80000000 gives bus_ack and a one-cycle irq_rearm pulse in the next cycle. Any other write gives no ack, no bus error, no pop and no pulse.
- R3: With shr_en and mb_enable both high, a read is a shared hit when shr_lo <= addr[31:23] < shr_hi. The upper bound is exclusive. The board answers a shared hit only while token_held is high. Otherwise, and whenever mb_enable is low, it gives no ack, no bus error and no pop.
- R4: During and right after reset, token_held equals is_first and no response or pulse is active.
- R5: A word popped through the shared window while fifo_last is high completes one event. When the completed-event count reaches block_size (0 acts as 1), a board with is_last low drops token_held and pulses token_out for one cycle after that read, and its count restarts.
- R6: A board with is_last high keeps the token when its block completes. It answers its next shared read with a termination (bus_berr if berr_enable, else bus_ack with data 0) and pops nothing. It then releases the token unless is_first is also high.
- R7: A read that hits while the FIFO is empty pops nothing. It is answered by bus_berr when berr_enable is high, and otherwise by bus_ack with data 0.
- R8: A token_in pulse sets token_held from the next cycle.
- R9: bus_ack and bus_berr are never high together. Either one appears only in the cycle after a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Single-cycle bus request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Data or write acknowledge, one cycle after request |
| bus_berr | output | 1 | Bus error termination, one cycle after request |
| bus_rdata | output | 32 | Read data returned with bus_ack |
| priv_en | input | 1 | Private window enable |
| priv_base | input | 9 | Private window base, compared with addr[31:23] |
| shr_en | input | 1 | Shared window enable |
| shr_lo | input | 9 | Shared window lower limit (inclusive) |
| shr_hi | input | 9 | Shared window upper limit (exclusive) |
| mb_enable | input | 1 | Multi-board protocol enable |
| is_first | input | 1 | Board starts the chain |
| is_last | input | 1 | Board ends the chain |
| berr_enable | input | 1 | Allow bus error terminations |
| block_size | input | 16 | Events per token tenure |
| token_in | input | 1 | Token arrival pulse from the previous board |
| token_out | output | 1 | Token hand-off pulse to the next board |
| token_held | output | 1 | Token possession status |
| irq_rearm | output | 1 | One-cycle interrupt re-arm pulse |
| fifo_empty | input | 1 | Data FIFO empty |
| fifo_last | input | 1 | Head word is the last word of an event |
| fifo_data | input | 32 | Head word of the FIFO |
| fifo_pop | output | 1 | Pop the head word |

## Verification
A wrong event count or a stale done flag does not fail right away. It shows at the ports as a token_out pulse one read early or one read late, or as a termination in place of data. Each of these appears in the response cycle of the read that should have closed the block. A wrong token flag shows on the next shared read, as a missing response or as a response from a board that should be silent. A decode error at a window edge shows in the very next cycle, as an ack or pop where none was expected.

// File: rtl/crd_pkg.sv
package crd_pkg;
    // width of the address tag compared against window limits
    localparam int TAG_W = 9;

    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_ACK  = 2'd1,
        RSP_BERR = 2'd2
    } rsp_e;
endpackage

// File: rtl/crd_win_dec.sv
module crd_win_dec #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              priv_en,
    input  logic [TAG_W-1:0]  priv_base,
    input  logic              shr_en,
    input  logic              mb_enable,
    input  logic [TAG_W-1:0]  shr_lo,
    input  logic [TAG_W-1:0]  shr_hi,
    output logic              priv_hit,
    output logic              shr_hit
);
    localparam int OFS_W = ADDR_W - TAG_W;

    logic [TAG_W-1:0] tag;
    logic             shr_in_range;
    // offset within a window never affects decode
    logic             unused_ofs;

    assign tag        = addr[ADDR_W-1:OFS_W];
    assign unused_ofs = ^addr[OFS_W-1:0];

    always_comb begin
        priv_hit     = priv_en && (tag == priv_base);
        shr_in_range = shr_en && mb_enable && (tag >= shr_lo) && (tag < shr_hi);
        // private window wins where both match
        shr_hit      = shr_in_range && !priv_hit;
    end
endmodule

// File: rtl/crd_token_ctrl.sv
module crd_token_ctrl #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_first,
    input  logic             is_last,
    input  logic             token_in,
    input  logic             evt_done,
    input  logic             term_done,
    input  logic [CNT_W-1:0] block_size,
    output logic             token_held,
    output logic             blk_done,
    output logic             token_out
);
    typedef struct packed {
        logic             held;
        logic             done;
        logic             pass;
        logic [CNT_W-1:0] cnt;
    } tok_st_t;

    tok_st_t tok_d, tok_q;

    logic [CNT_W:0] size_eff;
    logic [CNT_W:0] cnt_inc;

    always_comb begin
        size_eff = (block_size == '0) ? (CNT_W+1)'(1) : {1'b0, block_size};
        cnt_inc  = {1'b0, tok_q.cnt} + (CNT_W+1)'(1);

        tok_d      = tok_q;
        tok_d.pass = 1'b0;

        if (token_in) begin
            tok_d.held = 1'b1;
        end

        if (evt_done) begin
            if (cnt_inc >= size_eff) begin
                tok_d.cnt = '0;
                if (is_last) begin
                    tok_d.done = 1'b1;
                end else begin
                    tok_d.held = 1'b0;
                    tok_d.pass = 1'b1;
                end
            end else begin
                tok_d.cnt = cnt_inc[CNT_W-1:0];
            end
        end

        if (term_done) begin
            tok_d.done = 1'b0;
            if (!is_first) begin
                tok_d.held = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok_q.held <= is_first;
            tok_q.done <= 1'b0;
            tok_q.pass <= 1'b0;
            tok_q.cnt  <= '0;
        end else begin
            tok_q <= tok_d;
        end
    end

    assign token_held = tok_q.held;
    assign blk_done   = tok_q.done;
    assign token_out  = tok_q.pass;
endmodule

// File: rtl/chain_readout_dec.sv
module chain_readout_dec #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_req,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic                    bus_ack,
    output logic                    bus_berr,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic                    priv_en,
    input  logic [crd_pkg::TAG_W-1:0] priv_base,
    input  logic                    shr_en,
    input  logic [crd_pkg::TAG_W-1:0] shr_lo,
    input  logic [crd_pkg::TAG_W-1:0] shr_hi,
    input  logic                    mb_enable,
    input  logic                    is_first,
    input  logic                    is_last,
    input  logic                    berr_enable,
    input  logic [CNT_W-1:0]        block_size,
    input  logic                    token_in,
    output logic                    token_out,
    output logic                    token_held,
    output logic                    irq_rearm,
    input  logic                    fifo_empty,
    input  logic                    fifo_last,
    input  logic [DATA_W-1:0]       fifo_data,
    output logic                    fifo_pop
);
    import crd_pkg::*;

    // re-arm word: only the top bit set
    localparam logic [DATA_W-1:0] REARM_WORD = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        rsp_e              rsp;
        logic [DATA_W-1:0] rdata;
        logic              rearm;
    } rsp_st_t;

    rsp_st_t r_d, r_q;

    logic priv_hit, shr_hit;
    logic blk_done;
    logic rd_cyc, priv_rd, shr_rd;
    logic want_data, serve, starve, term, rearm_hit, evt_done;

    crd_win_dec #(
        .ADDR_W (ADDR_W),
        .TAG_W  (TAG_W)
    ) win_i (
        .addr      (bus_addr),
        .priv_en   (priv_en),
        .priv_base (priv_base),
        .shr_en    (shr_en),
        .mb_enable (mb_enable),
        .shr_lo    (shr_lo),
        .shr_hi    (shr_hi),
        .priv_hit  (priv_hit),
        .shr_hit   (shr_hit)
    );

    always_comb begin
        rd_cyc    = bus_req && !bus_we;
        priv_rd   = rd_cyc && priv_hit;
        shr_rd    = rd_cyc && shr_hit && token_held;
        term      = shr_rd && blk_done;
        want_data = priv_rd || (shr_rd && !blk_done);
        serve     = want_data && !fifo_empty;
        starve    = want_data && fifo_empty;
        evt_done  = serve && shr_rd && fifo_last;
        rearm_hit = bus_req && bus_we && priv_hit && (bus_wdata == REARM_WORD);
    end

    crd_token_ctrl #(
        .CNT_W (CNT_W)
    ) tok_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .is_first   (is_first),
        .is_last    (is_last),
        .token_in   (token_in),
        .evt_done   (evt_done),
        .term_done  (term),
        .block_size (block_size),
        .token_held (token_held),
        .blk_done   (blk_done),
        .token_out  (token_out)
    );

    always_comb begin
        r_d.rsp   = RSP_NONE;
        r_d.rdata = '0;
        r_d.rearm = 1'b0;
        if (serve) begin
            r_d.rsp   = RSP_ACK;
            r_d.rdata = fifo_data;
        end else if (starve || term) begin
            r_d.rsp = berr_enable ? RSP_BERR : RSP_ACK;
        end else if (rearm_hit) begin
            r_d.rsp   = RSP_ACK;
            r_d.rearm = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.rsp   <= RSP_NONE;
            r_q.rdata <= '0;
            r_q.rearm <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign fifo_pop  = serve;
    assign bus_ack   = (r_q.rsp == RSP_ACK);
    assign bus_berr  = (r_q.rsp == RSP_BERR);
    assign bus_rdata = r_q.rdata;
    assign irq_rearm = r_q.rearm;
endmodule

// File: rtl/crd_checker.sv
module crd_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack,
    input logic              bus_berr,
    input logic              fifo_pop,
    input logic              fifo_empty,
    input logic              irq_rearm,
    input logic              token_out,
    input logic              token_held,
    input logic              token_in,
    input logic              is_last
);
    localparam logic [DATA_W-1:0] REARM_WORD = {1'b1, {(DATA_W-1){1'b0}}};

    p_resp_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ack && bus_berr));

    p_resp_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack || bus_berr) |-> $past(bus_req));

    p_pop_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (bus_req && !bus_we && !fifo_empty));

    p_rearm_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rearm |-> $past(bus_req && bus_we && (bus_wdata == REARM_WORD)));

    p_pass_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        token_out |-> ($past(token_held) && !token_held && !is_last));

    p_gain_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(token_held) |-> $past(token_in));
endmodule

bind chain_readout_dec crd_checker #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_ack    (bus_ack),
    .bus_berr   (bus_berr),
    .fifo_pop   (fifo_pop),
    .fifo_empty (fifo_empty),
    .irq_rearm  (irq_rearm),
    .token_out  (token_out),
    .token_held (token_held),
    .token_in   (token_in),
    .is_last    (is_last)
);

// File: tb/chain_readout_dec_tb_top.sv
`timescale 1ns/1ps
module chain_readout_dec_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic        bus_ack, bus_berr;
    logic [31:0] bus_rdata;
    logic        priv_en = 1'b1, shr_en = 1'b1, mb_enable = 1'b1;
    logic [8:0]  priv_base = 9'h012, shr_lo = 9'h020, shr_hi = 9'h022;
    logic        is_first = 1'b1, is_last = 1'b0, berr_enable = 1'b1;
    logic [15:0] block_size = 16'd2;
    logic        token_in = 1'b0;
    logic        token_out, token_held, irq_rearm;
    logic        fifo_empty, fifo_last, fifo_pop;
    logic [31:0] fifo_data;

    int head = 0;
    int level = 1000;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // FIFO model: word i = D000_0000 + i, odd words close an event
    assign fifo_empty = (head >= level);
    assign fifo_data  = 32'hD000_0000 + 32'(head);
    assign fifo_last  = head[0];
    always @(posedge clk) if (fifo_pop) head <= head + 1;

    always #5 clk = ~clk;

    chain_readout_dec dut_i (.*);

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [1:0]  rsp;   // 0 none, 1 ack, 2 berr
        logic        pop;
        logic        rearm;
        logic        tok;
    } vec_t;

    localparam vec_t VEC [13] = '{
        '{1'b0, 32'h0900_0000, 32'h0, 2'd1, 1'b1, 1'b0, 1'b0}, // R1 base
        '{1'b0, 32'h097F_FFFC, 32'h0, 2'd1, 1'b1, 1'b0, 1'b0}, // R1 top offset
        '{1'b0, 32'h0980_0000, 32'h0, 2'd0, 1'b0, 1'b0, 1'b0}, // R1 above
        '{1'b1, 32'h0900_0010, 32'h8000_0000, 2'd1, 1'b0, 1'b1, 1'b0}, // R2
        '{1'b1, 32'h0900_0010, 32'h0000_1234, 2'd0, 1'b0, 1'b0, 1'b0}, // R2
        '{1'b0, 32'h0FFF_FFFC, 32'h0, 2'd0, 1'b0, 1'b0, 1'b0}, // R3 below lo
        '{1'b0, 32'h1000_0000, 32'h0, 2'd1, 1'b1, 1'b0, 1'b0}, // R3 lo incl
        '{1'b0, 32'h10FF_FFFC, 32'h0, 2'd1, 1'b1, 1'b0, 1'b0}, // R3 evt 1
        '{1'b0, 32'h1100_0000, 32'h0, 2'd0, 1'b0, 1'b0, 1'b0}, // R3 hi excl
        '{1'b0, 32'h1080_0000, 32'h0, 2'd1, 1'b1, 1'b0, 1'b0}, // R5
        '{1'b0, 32'h1000_0004, 32'h0, 2'd1, 1'b1, 1'b0, 1'b1}, // R5 pass
        '{1'b0, 32'h1000_0008, 32'h0, 2'd0, 1'b0, 1'b0, 1'b0}, // R3 no token
        '{1'b0, 32'h0940_0000, 32'h0, 2'd1, 1'b1, 1'b0, 1'b0}  // R1 still
    };

    logic        g_ack, g_berr, g_rearm, g_tok;
    logic [31:0] g_data, g_exp_word;
    int          g_pop;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic do_op(input logic wr, input logic [31:0] a, input logic [31:0] d);
        int h0;
        @(negedge clk);
        bus_req = 1'b1; bus_we = wr; bus_addr = a; bus_wdata = d;
        h0 = head;
        g_exp_word = 32'hD000_0000 + 32'(h0);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        g_ack = bus_ack; g_berr = bus_berr; g_data = bus_rdata;
        g_rearm = irq_rearm; g_tok = token_out; g_pop = head - h0;
    endtask

    task automatic pulse_token;
        @(negedge clk); token_in = 1'b1;
        @(negedge clk); token_in = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R4 reset state, first board
        chk(token_held == 1'b1, "R4 token at reset", 32'(token_held), 32'd1);
        chk(!bus_ack && !bus_berr && !token_out, "R4 idle outputs", {bus_ack, bus_berr, token_out}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(token_held == 1'b1, "R4 token after reset", 32'(token_held), 32'd1);

        foreach (VEC[i]) begin
            do_op(VEC[i].wr, VEC[i].addr, VEC[i].wdata);
            chk({g_berr, g_ack} == VEC[i].rsp, $sformatf("R1/R2/R3 vec %0d response", i), {g_berr, g_ack}, VEC[i].rsp);
            chk(g_pop == int'(VEC[i].pop), $sformatf("R1/R3 vec %0d pop", i), g_pop, VEC[i].pop);
            if (VEC[i].pop)
                chk(g_data == g_exp_word, $sformatf("R1 vec %0d data", i), g_data, g_exp_word);
            chk(g_rearm == VEC[i].rearm, $sformatf("R2 vec %0d rearm", i), g_rearm, VEC[i].rearm);
            chk(g_tok == VEC[i].tok, $sformatf("R5 vec %0d token_out", i), g_tok, VEC[i].tok);
        end
        chk(token_held == 1'b0, "R5 token dropped", token_held, 0);

        // R8 token arrival
        pulse_token();
        chk(token_held == 1'b1, "R8 token gained", token_held, 1);

        // R6 last board: head is 7 (odd, event end)
        is_last = 1'b1; is_first = 1'b0;
        do_op(1'b0, 32'h1000_0000, 0);
        chk(g_ack && g_pop == 1, "R6 read 1", g_pop, 1);
        do_op(1'b0, 32'h1000_0000, 0);
        do_op(1'b0, 32'h1000_0000, 0);
        chk(g_ack && !g_tok && token_held, "R6 block done keeps token", {g_ack, g_tok, token_held}, 3'b101);
        do_op(1'b0, 32'h1000_0000, 0);
        chk(g_berr && !g_ack && g_pop == 0, "R6 terminating berr", {g_berr, g_ack, 30'(g_pop)}, 32'h8000_0000);
        chk(token_held == 1'b0, "R6 token released", token_held, 0);

        // R7 empty FIFO
        level = head;
        do_op(1'b0, 32'h0900_0000, 0);
        chk(g_berr && !g_ack && g_pop == 0, "R7 empty berr", {g_berr, g_ack}, 2'b10);
        berr_enable = 1'b0;
        do_op(1'b0, 32'h0900_0000, 0);
        chk(g_ack && !g_berr && g_data == 0 && g_pop == 0, "R7 empty ack zero", g_data, 0);
        berr_enable = 1'b1; level = 1000;

        // R3 protocol disabled: holder stays silent
        mb_enable = 1'b0;
        pulse_token();
        do_op(1'b0, 32'h1000_0000, 0);
        chk(!g_ack && !g_berr && g_pop == 0, "R3 mb disabled silent", {g_ack, g_berr}, 0);
        mb_enable = 1'b1;

        // R5 block_size 0 acts as one event; head is even here
        is_last = 1'b0; block_size = 16'd0;
        do_op(1'b0, 32'h1000_0000, 0);
        chk(g_ack && !g_tok, "R5 size0 mid-event", g_tok, 0);
        do_op(1'b0, 32'h1000_0000, 0);
        chk(g_ack && g_tok, "R5 size0 pass", g_tok, 1);

        // R4 reset of a non-first board
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(token_held == 1'b0, "R4 non-first reset", token_held, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule